// File: doc/BRIEF.md
# Sequential Booth-Recoded Signed Multiplier

This block multiplies two signed two's-complement operands of W bits (32 by default). It uses one recoding step per clock and a single adder/subtractor. A start pulse while the unit is idle captures both operands. The multiplier operand sits in the low half of a combined product register. The upper half is cleared, and a one-bit history cell to the right of bit 0 starts at zero.

On each of the W steps, the unit looks at bit 0 of the low half and at the history cell. The pair (bit 0, history) = 1,0 subtracts the multiplicand from the upper half. The pair 0,1 adds it. The pairs 0,0 and 1,1 leave the upper half alone. The upper half, the low half and the history cell then shift right together by one place, and the sign is copied into the top bit.

The upper-half arithmetic is one bit wider than W. This keeps the sign correct when the most negative multiplicand is subtracted. When the last step is done, busy drops and done pulses for a single cycle. The 2W-bit result appears as an upper word and a lower word, and it stays there until the next start is accepted.

Top module: `booth_seq_mult`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears busy, done, prod_hi and prod_lo to zero.
- R2: When start is high at an edge where busy is low, the block captures the operands. In the next cycle busy is 1, prod_hi is 0 and prod_lo equals the multiplier. Busy then stays high for exactly W cycles.
- R3: done is 1 for exactly one cycle, the first cycle in which busy is low again. done is 0 at all other times.
- R4: In the done cycle, {prod_hi, prod_lo} equals the full 2W-bit signed product of the captured operands. prod_hi holds bits 2W-1..W and prod_lo holds bits W-1..0.
- R5: With W = 4, multiplicand 2 and multiplier 7 give 8'b0000_1110. Multiplicand 2 and multiplier -3 give 8'b1111_1010.
- R6: The most negative value times itself gives the positive value 2^(2W-2). This is 8'h40 for W = 4 and 64'h4000_0000_0000_0000 for W = 32.
- R7: start is ignored while busy is high. A new start pulse or new operand values in that window change neither the run length nor the result.
- R8: While busy is low and start is low, prod_hi and prod_lo hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | High while recoding steps run |
| done | output | 1 | One-cycle pulse when the result is ready |
| prod_hi | output | W | Upper half of the signed product |
| prod_lo | output | W | Lower half of the signed product |

## Verification
A wrong recoding decision or a wrong shift inside the product register stays hidden while busy is high. It shows up at the ports in the done cycle, W+1 cycles after start, as a wrong upper or lower word. A miscounted step counter shows up sooner, as busy falling in the wrong cycle, which is caught on the very cycle it happens. The bench checks every 4-bit operand pair and a set of 32-bit corner values, including the most negative operand on both inputs. It also sends start pulses during a run to show that a stray start cannot restart or corrupt the sequence.

// File: rtl/booth_pkg.sv
// Shared types for the Booth multiplier.
// Assumes nothing beyond the 2-bit encoding of the step operation.
package booth_pkg;
    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
// Radix-2 recoder: turns the current multiplier bit and the history bit
// into keep, add or subtract. Purely combinational.
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      hist_bit,
    output booth_op_e op
);
    // Map the bit pair to a step operation.
    always_comb begin
        unique case ({cur_bit, hist_bit})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_KEEP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
// Upper-half adder/subtractor, W+1 bits wide. The multiplicand is
// sign-extended by one bit, so subtracting the most negative value keeps
// the correct sign. Assumes acc already carries its own sign extension.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W:0]   acc,
    input  logic [W-1:0] mcand,
    input  booth_op_e    op,
    output logic [W:0]   sum
);
    logic [W:0] ext;

    // Sign-extend the multiplicand to the accumulator width.
    always_comb ext = {mcand[W-1], mcand};

    // Apply the selected operation to the upper half.
    always_comb begin
        unique case (op)
            OP_ADD:  sum = acc + ext;
            OP_SUB:  sum = acc - ext;
            default: sum = acc;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
// Step sequencer: accepts start only when idle, runs exactly W steps,
// then pulses done for one cycle. Assumes W >= 2.
module booth_ctrl #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);
    localparam int CW = $clog2(W) + 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;

    // Count the steps and produce busy and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    // Load strobes on an accepted start; a step happens on every busy cycle.
    always_comb begin
        load = start & ~busy;
        step = busy;
    end
endmodule

// File: rtl/booth_preg.sv
// Combined product register: a (W+1)-bit upper accumulator, a W-bit lower
// half that starts out holding the multiplier, and a one-bit history cell.
// It also holds the captured multiplicand. Assumes load and step are never
// high together.
module booth_preg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    input  logic [W:0]   sum,
    output logic [W:0]   acc,
    output logic [W-1:0] low,
    output logic         hist,
    output logic [W-1:0] mcand_q
);
    // Load the operands, or apply one arithmetic right shift of the whole register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            low     <= '0;
            hist    <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc     <= '0;
            low     <= mplier_in;
            hist    <= 1'b0;
            mcand_q <= mcand_in;
        end else if (step) begin
            acc  <= {sum[W], sum[W:1]};
            low  <= {sum[0], low[W-1:1]};
            hist <= low[0];
        end
    end
endmodule

// File: rtl/booth_seq_mult.sv
// Sequential radix-2 Booth multiplier, top level. Multiplies two signed
// W-bit operands in W clock steps and returns the 2W-bit signed product as
// an upper and a lower word. Assumes start is acted on only when idle.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo
);
    localparam int AW = W + 1;

    logic          load;
    logic          step;
    booth_op_e     op;
    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic [W-1:0]  low;
    logic          hist;
    logic [W-1:0]  mcand_q;

    booth_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    booth_recode u_rec (
        .cur_bit  (low[0]),
        .hist_bit (hist),
        .op       (op)
    );

    booth_addsub #(.W(W)) u_as (
        .acc   (acc),
        .mcand (mcand_q),
        .op    (op),
        .sum   (sum)
    );

    booth_preg #(.W(W)) u_preg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .sum       (sum),
        .acc       (acc),
        .low       (low),
        .hist      (hist),
        .mcand_q   (mcand_q)
    );

    // Drive the output words from the product register; the extra sign bit stays inside.
    always_comb begin
        prod_hi = acc[W-1:0];
        prod_lo = low;
    end
endmodule

// File: rtl/booth_seq_mult_chk.sv
// Port-level protocol checker for booth_seq_mult, attached with bind.
// Keeps its own busy-cycle counter, so the run length is checked without
// a long $past window.
module booth_seq_mult_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] mplier,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo
);
    int unsigned busy_cycles;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cycles <= 0;
        else if (busy) busy_cycles <= busy_cycles + 1;
        else           busy_cycles <= 0;
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && prod_hi == '0 && prod_lo == $past(mplier)));

    a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (busy_cycles == W));

    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cycles < W));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && busy_cycles < W - 1) |=> busy);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/sim_booth_seq_mult.sv
// Behavioural cycle model: tracks busy and done with a plain integer
// counter and computes the product with the language's signed multiply.
module ref_booth #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         e_busy,
    output logic         e_done,
    output logic         e_valid,
    output logic [W-1:0] e_hi,
    output logic [W-1:0] e_lo
);
    int n;
    logic [2*W-1:0] pend;

    function automatic logic [2*W-1:0] smul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic signed [W-1:0]   sx;
        logic signed [W-1:0]   sy;
        logic signed [2*W-1:0] p;
        sx = x;
        sy = y;
        p  = sx * sy;
        return p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_busy <= 0; e_done <= 0; e_valid <= 1; e_hi <= '0; e_lo <= '0; n <= 0;
        end else begin
            e_done <= 0;
            if (e_busy) begin
                n <= n + 1;
                if (n + 1 == W) begin
                    e_busy  <= 0;
                    e_done  <= 1;
                    e_valid <= 1;
                    e_hi    <= pend[2*W-1:W];
                    e_lo    <= pend[W-1:0];
                end
            end else if (start) begin
                e_busy  <= 1;
                n       <= 0;
                e_valid <= 0;
                pend    <= smul(a, b);
            end
        end
    end
endmodule

module sim_booth_seq_mult;
    localparam int CLK_PERIOD = 10;
    localparam int WS = 4;
    localparam int WL = 32;

    logic clk = 0;
    logic rst_n = 0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit wd_fired = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Large instance (default width)
    logic          s0 = 0;
    logic [WL-1:0] a0 = '0, b0 = '0, hi0, lo0, xhi0, xlo0;
    logic          busy0, done0, xb0, xd0, xv0;
    booth_seq_mult u0 (.clk(clk), .rst_n(rst_n), .start(s0), .mcand(a0), .mplier(b0),
                       .busy(busy0), .done(done0), .prod_hi(hi0), .prod_lo(lo0));
    ref_booth #(.W(WL)) m0 (.clk(clk), .rst_n(rst_n), .start(s0), .a(a0), .b(b0),
                            .e_busy(xb0), .e_done(xd0), .e_valid(xv0), .e_hi(xhi0), .e_lo(xlo0));

    // Small instance (4-bit, exhaustive)
    logic          s1 = 0;
    logic [WS-1:0] a1 = '0, b1 = '0, hi1, lo1, xhi1, xlo1;
    logic          busy1, done1, xb1, xd1, xv1;
    booth_seq_mult #(.W(WS)) u1 (.clk(clk), .rst_n(rst_n), .start(s1), .mcand(a1), .mplier(b1),
                       .busy(busy1), .done(done1), .prod_hi(hi1), .prod_lo(lo1));
    ref_booth #(.W(WS)) m1 (.clk(clk), .rst_n(rst_n), .start(s1), .a(a1), .b(b1),
                            .e_busy(xb1), .e_done(xd1), .e_valid(xv1), .e_hi(xhi1), .e_lo(xlo1));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare both instances against their models on every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy0 == xb0, "R2 busy w32", 64'(busy0), 64'(xb0));
            check(done0 == xd0, "R3 done w32", 64'(done0), 64'(xd0));
            if (xv0) check({hi0, lo0} == {xhi0, xlo0}, "R4/R8 product w32", {hi0, lo0}, {xhi0, xlo0});
            check(busy1 == xb1, "R2 busy w4", 64'(busy1), 64'(xb1));
            check(done1 == xd1, "R3 done w4", 64'(done1), 64'(xd1));
            if (xv1) check({hi1, lo1} == {xhi1, xlo1}, "R4/R8 product w4", 64'({hi1, lo1}), 64'({xhi1, xlo1}));
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd_fired) begin
            wd_fired = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            finish_run();
        end
    end

    // Run one 4-bit operation; optionally pulse start mid-run (R7) and check a known result.
    task automatic op4(input logic [3:0] a, input logic [3:0] b, input bit poke,
                       input bit chk, input logic [7:0] exp, input string req);
        @(negedge clk); s1 = 1; a1 = a; b1 = b;
        @(negedge clk); s1 = 0;
        if (poke) begin s1 = 1; a1 = ~a; b1 = b + 4'd3; end
        @(negedge clk); s1 = 0;
        while (!done1) @(negedge clk);
        if (chk) check({hi1, lo1} == exp, req, 64'({hi1, lo1}), 64'(exp));
    endtask

    task automatic op32(input logic [31:0] a, input logic [31:0] b, input bit poke,
                        input bit chk, input logic [63:0] exp, input string req);
        @(negedge clk); s0 = 1; a0 = a; b0 = b;
        @(negedge clk); s0 = 0;
        if (poke) begin s0 = 1; a0 = 32'h1234_5678; b0 = 32'h8765_4321; end
        @(negedge clk); s0 = 0;
        while (!done0) @(negedge clk);
        if (chk) check({hi0, lo0} == exp, req, {hi0, lo0}, exp);
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy0 && !done0 && hi0 == '0 && lo0 == '0, "R1 reset w32", {hi0, lo0}, 64'd0);
        check(!busy1 && !done1 && hi1 == '0 && lo1 == '0, "R1 reset w4", 64'({hi1, lo1}), 64'd0);
        rst_n = 1;

        // R5: stated 4-bit examples
        op4(4'd2, 4'd7, 0, 1, 8'b0000_1110, "R5 2x7");
        op4(4'd2, 4'hD, 0, 1, 8'b1111_1010, "R5 2x-3");
        // R6: most negative squared
        op4(4'h8, 4'h8, 0, 1, 8'h40, "R6 -8x-8 w4");
        op4(4'h8, 4'h7, 1, 1, 8'hC8, "R7 -8x7 with mid-run start");

        // R4/R7: every 4-bit pair, every other run with a stray start
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                op4(4'(i), 4'(j), ((i + j) % 2) == 1, 0, 8'h00, "R4");

        // R8: idle hold while the operands change
        held = 64'({hi1, lo1});
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); a1 = 4'(k); b1 = 4'(k + 7);
        end
        check(64'({hi1, lo1}) == held, "R8 idle hold w4", 64'({hi1, lo1}), held);

        // 32-bit corner values
        op32(32'h8000_0000, 32'h8000_0000, 0, 1, 64'h4000_0000_0000_0000, "R6 min x min w32");
        op32(32'hFFFF_FFFF, 32'd1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R4 -1x1 w32");
        op32(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 64'h3FFF_FFFF_0000_0001, "R7 max x max with mid-run start");
        op32(32'h8000_0000, 32'h7FFF_FFFF, 0, 1, 64'hC000_0000_8000_0000, "R4 min x max w32");
        op32(32'd0, 32'hDEAD_BEEF, 0, 1, 64'd0, "R4 zero x value w32");
        op32(32'h5555_5555, 32'hAAAA_AAAA, 1, 0, 64'd0, "R4");
        held = {hi0, lo0};
        repeat (4) @(negedge clk);
        check({hi0, lo0} == held, "R8 idle hold w32", {hi0, lo0}, held);

        finish_run();
    end
endmodule